// File: doc/BRIEF.md
# Clock Output Pin Function Selector

This block decides what a single shared output pin carries. The pin can carry one of three divided clocks, the external bus clock, the address latch enable strobe, or nothing. When it carries nothing it is handed back to general port I/O. The choice depends on the operating mode (single-chip or expanded bus), an output-enable control bit, a 2-bit clock select code and a 2-bit pin-function code. The clock sources and the strobe are generated elsewhere and arrive as inputs.

The two slower divided clocks can be frozen low while the core sits in a wait state, if a wait-stop control bit allows it. The freeze is applied through a latch-based gate that only changes its enable while the source clock is low. A freeze or release requested in the middle of a high phase therefore takes effect only after that high phase ends, and no runt pulse reaches the pin. The fastest clock choice is never frozen.

All control inputs are static configuration levels and the pin is a plain level output, so the block has no stream interface and no back-pressure. The system clock input serves only the reset and the embedded checks.

Top module: `clkout_pin_sel`

## Requirements
- R1: While `rst_n` is low, `pin_oe` is 0, `port_io` is 1 and `pin_out` is 0, whatever the other inputs are.
- R2: In single-chip mode (`expanded_mode`=0) with `clkout_en`=1 and `clk_sel` not 00, the pin carries `f8_clk` for code 01, `f32_clk` for code 10 and `fc_clk` for code 11, with `pin_oe`=1.
- R3: In single-chip mode every other combination, including `clkout_en`=0 with `clk_sel`=00, gives port I/O and never drives `bus_clk`. `pin_fn` has no effect in this mode.
- R4: In expanded mode with `pin_fn` not 01 and `clkout_en`=1, a nonzero `clk_sel` picks the divided clock using the same codes as R2.
- R5: In expanded mode with `pin_fn` not 01, `clkout_en`=0 and `clk_sel`=00, the pin carries `bus_clk`.
- R6: In expanded mode with `pin_fn` not 01, `clkout_en`=1 and `clk_sel`=00, the pin is port I/O.
- R7: In expanded mode with `pin_fn`=01 and `clk_sel`=00, the pin carries `ale_in` whatever `clkout_en` holds.
- R8: In expanded mode, `pin_fn`=01 with a nonzero `clk_sel`, and `pin_fn` not 01 with `clkout_en`=0 and a nonzero `clk_sel`, both give port I/O.
- R9: In port I/O, `port_io`=1, `pin_oe`=0 and `pin_out`=0. For every driven choice, `port_io`=0 and `pin_oe`=1.
- R10: While `wait_stop_en`=1 and `wait_active`=1, an `f8_clk` or `f32_clk` selection holds `pin_out` at 0. An `fc_clk` selection keeps following its source. `wait_active` alone has no effect.
- R11: A freeze or release of a gated clock takes effect only at a low phase of that source. If a freeze is requested while the source is high, the pin stays high until the source falls. If a release is requested while the source is high, the pin stays low until the source has been low once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for reset timing and checks |
| rst_n | input | 1 | Active-low asynchronous reset |
| f8_clk | input | 1 | Divided clock source selected by code 01 |
| f32_clk | input | 1 | Divided clock source selected by code 10 |
| fc_clk | input | 1 | Clock source selected by code 11, never frozen |
| bus_clk | input | 1 | External bus clock |
| ale_in | input | 1 | Address latch enable strobe |
| expanded_mode | input | 1 | 0 = single-chip, 1 = expanded bus mode |
| clkout_en | input | 1 | Clock output enable control bit |
| clk_sel | input | 2 | Clock select code |
| pin_fn | input | 2 | Pin function code; 01 claims the pin for ALE |
| wait_stop_en | input | 1 | Allows freezing the f8/f32 output during wait |
| wait_active | input | 1 | Core is in a wait state |
| pin_out | output | 1 | Value driven on the pin |
| pin_oe | output | 1 | Pin output enable |
| port_io | output | 1 | Pin is handed to general port I/O |

## Verification
Every routing result is combinational, so it is valid in the same cycle as the stimulus and has no register delay. The bench changes inputs on a falling system clock edge, lets one rising edge pass, and samples on the next falling edge. Gating results depend on the order of source-clock phases and not on the system clock. For those, the bench moves the source level and the wait controls in separate steps and checks the pin after each step.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
  localparam int SEL_W = 2;
  localparam int FN_W  = 2;
  localparam int N_GATED = 2;

  localparam logic [SEL_W-1:0] SEL_NONE = 2'b00;
  localparam logic [SEL_W-1:0] SEL_F8   = 2'b01;
  localparam logic [SEL_W-1:0] SEL_F32  = 2'b10;
  localparam logic [SEL_W-1:0] SEL_FC   = 2'b11;
  localparam logic [FN_W-1:0]  FN_ALE   = 2'b01;

  typedef enum logic [2:0] {
    RT_PORT = 3'd0,
    RT_F8   = 3'd1,
    RT_F32  = 3'd2,
    RT_FC   = 3'd3,
    RT_BCLK = 3'd4,
    RT_ALE  = 3'd5
  } route_e;
endpackage

// File: rtl/clkout_route_dec.sv
module clkout_route_dec
  import clkout_pkg::*;
(
  input  logic             expanded,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  input  logic [FN_W-1:0]  fn,
  output route_e           route
);
  route_e sel_route;

  always_comb begin
    unique case (sel)
      SEL_F8:  sel_route = RT_F8;
      SEL_F32: sel_route = RT_F32;
      SEL_FC:  sel_route = RT_FC;
      default: sel_route = RT_PORT;
    endcase
  end

  always_comb begin
    route = RT_PORT;
    if (!expanded) begin
      if (en && sel != SEL_NONE) route = sel_route;
    end else if (fn == FN_ALE) begin
      if (sel == SEL_NONE) route = RT_ALE;
    end else if (en) begin
      if (sel != SEL_NONE) route = sel_route;
    end else if (sel == SEL_NONE) begin
      route = RT_BCLK;
    end
  end
endmodule

// File: rtl/clkout_icg.sv
module clkout_icg (
  input  logic rst_n,
  input  logic src,
  input  logic stop,
  output logic gclk
);
  logic en_q;

  always_latch begin
    if (!rst_n)   en_q = 1'b1;
    else if (!src) en_q = ~stop;
  end

  assign gclk = src & en_q;
endmodule

// File: rtl/clkout_drive.sv
module clkout_drive
  import clkout_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  route_e route,
  input  logic   g_f8,
  input  logic   g_f32,
  input  logic   fc,
  input  logic   bclk,
  input  logic   ale,
  output logic   pin_out,
  output logic   pin_oe,
  output logic   port_io
);
  route_e eff;

  always_comb eff = rst_n ? route : RT_PORT;

  always_comb begin
    pin_out = 1'b0;
    unique case (eff)
      RT_F8:   pin_out = g_f8;
      RT_F32:  pin_out = g_f32;
      RT_FC:   pin_out = fc;
      RT_BCLK: pin_out = bclk;
      RT_ALE:  pin_out = ale;
      default: pin_out = 1'b0;
    endcase
  end

  assign port_io = (eff == RT_PORT);
  assign pin_oe  = (eff != RT_PORT);

  // R9
  port_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_io |-> (!pin_oe && !pin_out));

  // R1
  always @(posedge clk)
    if (!rst_n) reset_idle_chk: assert (!pin_oe && port_io && !pin_out);
endmodule

// File: rtl/clkout_pin_sel.sv
module clkout_pin_sel
  import clkout_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             f8_clk,
  input  logic             f32_clk,
  input  logic             fc_clk,
  input  logic             bus_clk,
  input  logic             ale_in,
  input  logic             expanded_mode,
  input  logic             clkout_en,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic [FN_W-1:0]  pin_fn,
  input  logic             wait_stop_en,
  input  logic             wait_active,
  output logic             pin_out,
  output logic             pin_oe,
  output logic             port_io
);
  route_e route;
  logic   stop_req;
  logic [N_GATED-1:0] raw_src;
  logic [N_GATED-1:0] gated_src;

  assign stop_req = wait_stop_en & wait_active;
  assign raw_src  = {f32_clk, f8_clk};

  clkout_route_dec u_dec (
    .expanded (expanded_mode),
    .en       (clkout_en),
    .sel      (clk_sel),
    .fn       (pin_fn),
    .route    (route)
  );

  for (genvar gi = 0; gi < N_GATED; gi++) begin : g_gate
    clkout_icg u_icg (
      .rst_n (rst_n),
      .src   (raw_src[gi]),
      .stop  (stop_req),
      .gclk  (gated_src[gi])
    );
  end

  clkout_drive u_drv (
    .clk     (clk),
    .rst_n   (rst_n),
    .route   (route),
    .g_f8    (gated_src[0]),
    .g_f32   (gated_src[1]),
    .fc      (fc_clk),
    .bclk    (bus_clk),
    .ale     (ale_in),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .port_io (port_io)
  );

  // R7
  ale_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expanded_mode && pin_fn == FN_ALE && clk_sel == SEL_NONE)
      |-> (pin_oe && pin_out == ale_in));

  // R5
  bus_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expanded_mode && pin_fn != FN_ALE && !clkout_en && clk_sel == SEL_NONE)
      |-> (pin_oe && pin_out == bus_clk));

  // R3
  single_no_bclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!expanded_mode && !clkout_en) |-> port_io);

  // R10
  f8_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stop_req && !f8_clk) && stop_req && route == RT_F8) |-> !pin_out);

  // R10
  fc_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (route == RT_FC) |-> (pin_out == fc_clk));
endmodule

// File: tb/tb_clkout_pin_sel.sv
module tb_clkout_pin_sel;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic f8_clk = 0, f32_clk = 0, fc_clk = 0, bus_clk = 0, ale_in = 0;
  logic expanded_mode = 0, clkout_en = 0, wait_stop_en = 0, wait_active = 0;
  logic [1:0] clk_sel = 0, pin_fn = 0;
  logic pin_out, pin_oe, port_io;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  clkout_pin_sel dut (.*);

  task automatic settle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [2:0] exp_v);
    logic [2:0] act;
    act = {pin_out, pin_oe, port_io};
    n_vec++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s: {out,oe,port}=%b expected %b (mode=%0b en=%0b sel=%b fn=%b)",
               req, act, exp_v, expanded_mode, clkout_en, clk_sel, pin_fn);
    end
  endtask

  // Expected routing: 0 port,1 f8,2 f32,3 fc,4 bclk,5 ale
  function automatic int exp_route(bit m, bit en, logic [1:0] s, logic [1:0] f);
    if (!m) return (en && s != 0) ? int'(s) : 0;
    if (f == 2'b01) return (s == 0) ? 5 : 0;
    if (en) return (s != 0) ? int'(s) : 0;
    return (s == 0) ? 4 : 0;
  endfunction

  function automatic string tag(bit m, bit en, logic [1:0] s, logic [1:0] f);
    if (!m) return (en && s != 0) ? "R2" : "R3";
    if (f == 2'b01) return (s == 0) ? "R7" : "R8";
    if (en) return (s != 0) ? "R4" : "R6";
    return (s == 0) ? "R5" : "R8";
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset forces port I/O even with a driving configuration
    expanded_mode = 1; clkout_en = 0; clk_sel = 0; pin_fn = 0; bus_clk = 1;
    settle();
    check("R1", 3'b001);
    clkout_en = 1; clk_sel = 2'b11; fc_clk = 1;
    settle();
    check("R1", 3'b001);
    fc_clk = 0; bus_clk = 0;
    @(negedge clk); rst_n = 1;
    settle();

    // Sweep all configurations, each source high alone plus all low
    for (int m = 0; m < 2; m++)
      for (int en = 0; en < 2; en++)
        for (int s = 0; s < 4; s++)
          for (int f = 0; f < 4; f++)
            for (int p = 0; p < 6; p++) begin
              int r;
              logic ev;
              expanded_mode = m[0]; clkout_en = en[0];
              clk_sel = s[1:0]; pin_fn = f[1:0];
              {ale_in, bus_clk, fc_clk, f32_clk, f8_clk} = (p == 0) ? 5'b0 : 5'(1 << (p - 1));
              settle();
              r = exp_route(m[0], en[0], s[1:0], f[1:0]);
              ev = (r != 0) && (p == r);
              // R9: port I/O quiet, driven choices enable the pin
              check(tag(m[0], en[0], s[1:0], f[1:0]), (r == 0) ? 3'b001 : {ev, 2'b10});
            end
    {ale_in, bus_clk, fc_clk, f32_clk, f8_clk} = 5'b0;

    // R10 / R11: gating on f8 and f32 in single-chip mode
    expanded_mode = 0; clkout_en = 1;
    for (int g = 1; g <= 2; g++) begin
      clk_sel = 2'(g);
      f8_clk = 0; f32_clk = 0; wait_stop_en = 0; wait_active = 0;
      settle();
      // R10: wait_active alone has no effect
      wait_active = 1; settle();
      if (g == 1) f8_clk = 1; else f32_clk = 1;
      settle(); check("R10", 3'b110);
      f8_clk = 0; f32_clk = 0; settle();
      // R10: freeze while source low
      wait_stop_en = 1; settle();
      if (g == 1) f8_clk = 1; else f32_clk = 1;
      settle(); check("R10", 3'b010);
      // R11: release while source high stays low
      wait_stop_en = 0; settle(); check("R11", 3'b010);
      f8_clk = 0; f32_clk = 0; settle(); check("R11", 3'b010);
      if (g == 1) f8_clk = 1; else f32_clk = 1;
      settle(); check("R11", 3'b110);
      // R11: freeze while high keeps pin high until the fall
      wait_stop_en = 1; settle(); check("R11", 3'b110);
      f8_clk = 0; f32_clk = 0; settle(); check("R11", 3'b010);
      if (g == 1) f8_clk = 1; else f32_clk = 1;
      settle(); check("R10", 3'b010);
      f8_clk = 0; f32_clk = 0; wait_stop_en = 0; wait_active = 0; settle();
    end

    // R10: fc keeps running during a frozen wait
    clk_sel = 2'b11; wait_stop_en = 1; wait_active = 1; settle();
    fc_clk = 1; settle(); check("R10", 3'b110);
    fc_clk = 0; settle(); check("R10", 3'b010);
    wait_stop_en = 0; wait_active = 0; settle();

    // R1: reset re-asserted mid-run returns the pin to port I/O
    fc_clk = 1; rst_n = 0; settle(); check("R1", 3'b001);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule